// File: doc/BRIEF.md
# Strided Region Operand Gather

This block fetches one source operand for a SIMD instruction from a banked register file. The operand is described as a two-dimensional region: a starting register, an element offset inside it, a row pitch (vertical stride), a row length (width), a step between elements in a row (horizontal stride), an element type and an execution size. The block walks the region one element per clock. It reads each element from the byte-addressed register storage and places the results, in lane order, into a contiguous vector of 32-bit lane slots.

Strided regions may run past the end of their starting register. They continue into the next registers without any special handling. Typical uses are taking the low or high 32-bit halves of 64-bit pairs, broadcasting one scalar into every lane, and reading narrow types packed many to a register. The register storage lives inside the block. A whole-register write port lets the surrounding logic, or a test, load it.

A gather starts with a one-cycle `start` pulse while the block is idle. Completion is signalled by a one-cycle `done` pulse. When `done` comes with `err` low, the lane vector is valid.

Top module: `regrg_gather`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and every lane slot reads 0.
- R2: Lane i reads the element at element offset sub + (i / width) * vstride + (i % width) * hstride, at byte address base*32 + offset*size. Type code 0 is a 1-byte element, 1 is 2 bytes, 2 is 4 bytes. Bytes are assembled little-endian, with the lowest address in bits 7:0.
- R3: The sub-register offset counts elements of the operand type, not bytes. For dwords starting at register 10 with vstride 8, width 4, hstride 2 and 8 lanes, sub 0 yields the even dwords of registers 10 and 11, and sub 1 yields the odd dwords.
- R4: Addresses that pass the end of a 32-byte register continue into the following register.
- R5: Execution size code 0 gives 8 lanes, 1 gives 16 and 2 gives 32. Lane slots at or above the execution size read 0 after the gather.
- R6: Byte and word elements are zero-extended into their 32-bit lane slots.
- R7: One element is fetched per clock. For a valid gather of N lanes, `done` is high for exactly one cycle, N cycles after the cycle in which `start` was taken, with `err` low.
- R8: A descriptor is rejected when its width is not a power of two, its width exceeds the execution size, its type code is 3 or its size code is 3. A rejected descriptor gives `done` with `err` high in the cycle after `start`, and all lane slots read 0.
- R9: When any element would lie beyond register 127, the walk stops at that element and `done` and `err` are raised together in the cycle after the failing fetch. The address never wraps to register 0.
- R10: A `start` pulse that arrives while `busy` is high is ignored. It neither alters the running gather nor produces an extra `done`.
- R11: The write port replaces a whole register in one cycle, and later gathers see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_reg | input | 7 | Register number to write |
| wr_data | input | 256 | Register contents, byte 0 in bits 7:0 |
| start | input | 1 | Begin a gather (taken only when idle) |
| base_reg | input | 7 | Starting register number |
| sub_elem | input | 5 | Element offset within the starting register |
| vstride | input | 6 | Element step between rows |
| width | input | 6 | Elements per row |
| hstride | input | 6 | Element step within a row |
| etype | input | 2 | Element type code |
| xsize | input | 2 | Execution size code |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Gather failed, qualified by done |
| lanes | output | 1024 | 32 lane slots of 32 bits, lane 0 in bits 31:0 |

## Verification
The bench builds the block with its default parameters: 128 registers of 32 bytes and 32 lane slots. With these values all three execution sizes can be reached, and so can regions that cross from one register into the next and regions that run past the top register. Because each register is 32 bytes, a dword region with row pitch 8 covers exactly two registers. This makes the even and odd half extraction observable, and it places the overflow boundary at a lane number the bench can predict.

// File: rtl/regrg_pkg.sv
package regrg_pkg;

    localparam int NREGS     = 128;
    localparam int REG_BYTES = 32;
    localparam int MAX_LANES = 32;
    localparam int LANE_W    = 32;
    localparam int SUB_W     = 5;
    localparam int STR_W     = 6;

    localparam int REG_BITS  = REG_BYTES * 8;
    localparam int RIDX_W    = $clog2(NREGS);
    localparam int BOFF_W    = $clog2(REG_BYTES);
    localparam int LIDX_W    = $clog2(MAX_LANES);
    localparam int OFF_W     = SUB_W + 2 * (LIDX_W + STR_W) + 1;
    localparam int ADDR_W    = OFF_W + 3 + 1;
    localparam int ELEM_MAXB = LANE_W / 8;

    typedef enum logic [1:0] {
        ET_BYTE  = 2'd0,
        ET_WORD  = 2'd1,
        ET_DWORD = 2'd2,
        ET_BAD   = 2'd3
    } etype_e;

    typedef enum logic [1:0] {
        XS_8   = 2'd0,
        XS_16  = 2'd1,
        XS_32  = 2'd2,
        XS_BAD = 2'd3
    } xsize_e;

    typedef struct packed {
        logic [RIDX_W-1:0] base;
        logic [SUB_W-1:0]  sub;
        logic [STR_W-1:0]  vs;
        logic [STR_W-1:0]  wd;
        logic [STR_W-1:0]  hs;
        etype_e            et;
    } region_t;

    function automatic int unsigned elem_bytes(etype_e t);
        return 32'd1 << t;
    endfunction

endpackage

// File: rtl/regrg_check.sv
module regrg_check
    import regrg_pkg::*;
(
    input  etype_e             et,
    input  xsize_e             xs,
    input  logic [STR_W-1:0]   wd,
    output logic               ok,
    output logic [LIDX_W:0]    nlanes
);
    always_comb begin
        nlanes = '0;
        ok     = 1'b0;
        if (xs != XS_BAD && et != ET_BAD) begin
            nlanes = (LIDX_W+1)'(8) << xs;
            ok     = (wd != '0) && ((wd & (wd - 1'b1)) == '0)
                     && (int'(wd) <= int'(nlanes));
        end
    end

    // R8: an accepted width always carries exactly one set bit
    always_comb begin
        if (ok) p_width_pow2_r8: assert ($countones(wd) == 1);
    end
endmodule

// File: rtl/regrg_addr.sv
module regrg_addr
    import regrg_pkg::*;
(
    input  region_t             rg,
    input  logic [LIDX_W-1:0]   row,
    input  logic [LIDX_W-1:0]   col,
    output logic [ADDR_W-1:0]   addr,
    output logic                oor
);
    logic [OFF_W-1:0] off;

    always_comb begin
        off  = OFF_W'(rg.sub)
             + OFF_W'(row) * OFF_W'(rg.vs)
             + OFF_W'(col) * OFF_W'(rg.hs);
        addr = (ADDR_W'(rg.base) << BOFF_W) + (ADDR_W'(off) << rg.et);
        oor  = (addr >> BOFF_W) >= ADDR_W'(NREGS);
    end
endmodule

// File: rtl/regrg_file.sv
module regrg_file
    import regrg_pkg::*;
(
    input  logic                clk,
    input  logic                wr_en,
    input  logic [RIDX_W-1:0]   wr_reg,
    input  logic [REG_BITS-1:0] wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  etype_e              rd_type,
    output logic [LANE_W-1:0]   rd_data
);
    logic [REG_BITS-1:0] mem [NREGS];
    logic [REG_BITS-1:0] row_bits;
    logic [ADDR_W-BOFF_W-1:0] ridx;
    logic [BOFF_W-1:0] boff;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_reg] <= wr_data;
    end

    always_comb begin
        ridx     = rd_addr[ADDR_W-1:BOFF_W];
        boff     = rd_addr[BOFF_W-1:0];
        row_bits = (int'(ridx) < NREGS) ? mem[ridx[RIDX_W-1:0]] : '0;
        rd_data  = '0;
        for (int j = 0; j < ELEM_MAXB; j++) begin
            int unsigned bidx;
            bidx = 32'(boff) + 32'(j);
            if (32'(j) < elem_bytes(rd_type) && bidx < REG_BYTES)
                rd_data[j*8 +: 8] = row_bits[bidx*8 +: 8];
        end
    end
endmodule

// File: rtl/regrg_gather.sv
module regrg_gather
    import regrg_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [RIDX_W-1:0]             wr_reg,
    input  logic [REG_BITS-1:0]           wr_data,
    input  logic                          start,
    input  logic [RIDX_W-1:0]             base_reg,
    input  logic [SUB_W-1:0]              sub_elem,
    input  logic [STR_W-1:0]              vstride,
    input  logic [STR_W-1:0]              width,
    input  logic [STR_W-1:0]              hstride,
    input  logic [1:0]                    etype,
    input  logic [1:0]                    xsize,
    output logic                          busy,
    output logic                          done,
    output logic                          err,
    output logic [MAX_LANES*LANE_W-1:0]   lanes
);
    region_t              rg_q;
    logic                 run_q, done_q, err_q;
    logic [LIDX_W-1:0]    lane_idx, row_q, col_q;
    logic [LIDX_W:0]      nl_q, nl_in;
    logic                 desc_ok, oor, last, accept, cap;
    logic [ADDR_W-1:0]    addr;
    logic [LANE_W-1:0]    rd_data;
    logic [LANE_W-1:0]    lane_q [MAX_LANES];

    regrg_check u_check (
        .et     (etype_e'(etype)),
        .xs     (xsize_e'(xsize)),
        .wd     (width),
        .ok     (desc_ok),
        .nlanes (nl_in)
    );

    regrg_addr u_addr (
        .rg   (rg_q),
        .row  (row_q),
        .col  (col_q),
        .addr (addr),
        .oor  (oor)
    );

    regrg_file u_file (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_reg  (wr_reg),
        .wr_data (wr_data),
        .rd_addr (addr),
        .rd_type (rg_q.et),
        .rd_data (rd_data)
    );

    assign accept = !run_q && start;
    assign cap    = run_q && !oor;
    assign last   = ({1'b0, lane_idx} == nl_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            lane_idx <= '0;
            row_q    <= '0;
            col_q    <= '0;
            nl_q     <= '0;
            rg_q     <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (!run_q) begin
                if (start) begin
                    if (!desc_ok) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end else begin
                        run_q    <= 1'b1;
                        rg_q     <= '{base: base_reg, sub: sub_elem, vs: vstride,
                                      wd: width, hs: hstride, et: etype_e'(etype)};
                        nl_q     <= nl_in;
                        lane_idx <= '0;
                        row_q    <= '0;
                        col_q    <= '0;
                    end
                end
            end else if (oor) begin
                run_q  <= 1'b0;
                done_q <= 1'b1;
                err_q  <= 1'b1;
            end else if (last) begin
                run_q  <= 1'b0;
                done_q <= 1'b1;
            end else begin
                lane_idx <= lane_idx + 1'b1;
                if ({1'b0, col_q} == rg_q.wd - 1'b1) begin
                    col_q <= '0;
                    row_q <= row_q + 1'b1;
                end else begin
                    col_q <= col_q + 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || accept)
                lane_q[g] <= '0;
            else if (cap && lane_idx == LIDX_W'(g))
                lane_q[g] <= rd_data;
        end
        assign lanes[g*LANE_W +: LANE_W] = lane_q[g];
    end

    assign busy = run_q;
    assign done = done_q;
    assign err  = err_q;

    // R7: the lane counter never passes the execution size
    p_lane_bound_r7: assert property (@(posedge clk) disable iff (rst)
        run_q |-> ({1'b0, lane_idx} < nl_q));

    // R2: the column within a row stays below the width
    p_col_bound_r2: assert property (@(posedge clk) disable iff (rst)
        run_q |-> ({1'b0, col_q} < rg_q.wd));

    // R9: an out-of-range element ends the walk with an error
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (run_q && oor) |=> (done && err && !busy));

    // R10: a start while busy leaves the latched region untouched
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (run_q && start) |=> $stable(rg_q));

    // R7: a clean completion only follows a walk
    p_done_after_walk_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> $past(run_q));
endmodule

// File: tb/regrg_gather_bench.sv
module regrg_gather_bench;
    import regrg_pkg::*;

    typedef struct {
        logic [MAX_LANES*LANE_W-1:0] lanes;
        bit    err;
        bit    cmp_lanes;
        int    lat;
        int    t0;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [RIDX_W-1:0] wr_reg = '0;
    logic [REG_BITS-1:0] wr_data = '0;
    logic start = 1'b0;
    logic [RIDX_W-1:0] base_reg = '0;
    logic [SUB_W-1:0] sub_elem = '0;
    logic [STR_W-1:0] vstride = '0, width = '0, hstride = '0;
    logic [1:0] etype = '0, xsize = '0;
    logic busy, done, err;
    logic [MAX_LANES*LANE_W-1:0] lanes;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;
    exp_t exp_q[$];
    logic [7:0] bmem [NREGS*REG_BYTES];

    regrg_gather u_regrg_gather (.*);

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        wait (cyc > 150000);
        n_bad++;
        $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
        summary();
    end

    function automatic logic [7:0] pat(int r, int b, int salt);
        return 8'(((r * 37) + (b * 11) + 5 + salt) ^ (r >> 1) ^ (b << 5));
    endfunction

    task automatic write_reg(int r, int salt);
        logic [REG_BITS-1:0] d;
        for (int b = 0; b < REG_BYTES; b++) begin
            d[b*8 +: 8] = pat(r, b, salt);
            bmem[r*REG_BYTES + b] = pat(r, b, salt);
        end
        @(negedge clk);
        wr_en = 1'b1; wr_reg = RIDX_W'(r); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: build the expected item from the requirements, push it, pulse start
    task automatic gather(int b, int s, int vs, int wd, int hs, int et, int xs,
                          string tag, bit poke_busy = 0);
        exp_t e;
        int n, sz;
        bit ok;
        e.lanes = '0; e.err = 0; e.cmp_lanes = 1; e.tag = tag;
        n  = (xs < 3) ? (8 << xs) : 0;
        sz = 1 << et;
        ok = (et < 3) && (xs < 3) && (wd > 0) && ((wd & (wd - 1)) == 0) && (wd <= n);
        if (!ok) begin
            e.err = 1; e.lat = 0;
        end else begin
            e.lat = n;
            for (int i = 0; i < n; i++) begin
                int off, a;
                off = s + (i / wd) * vs + (i % wd) * hs;
                a   = b * REG_BYTES + off * sz;
                if (a / REG_BYTES >= NREGS) begin
                    e.err = 1; e.lat = i + 1; e.cmp_lanes = 0;
                    break;
                end
                for (int k = 0; k < sz; k++)
                    e.lanes[i*LANE_W + k*8 +: 8] = bmem[a + k];
            end
        end
        @(negedge clk);
        base_reg = RIDX_W'(b); sub_elem = SUB_W'(s); vstride = STR_W'(vs);
        width = STR_W'(wd); hstride = STR_W'(hs); etype = 2'(et); xsize = 2'(xs);
        e.t0 = cyc;
        exp_q.push_back(e);
        start = 1'b1;
        @(negedge clk);
        if (poke_busy) begin
            // R10: second start while the first walk runs
            base_reg = 7'd0; sub_elem = 5'd1; width = 6'd1; vstride = 6'd1; hstride = 6'd0;
            etype = 2'd0; xsize = 2'd0;
            @(negedge clk);
        end
        start = 1'b0;
        wait (exp_q.size() == 0);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: pop and compare on every done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R10 unexpected done: actual done=1 expected done=0");
            end else begin
                exp_t e;
                int lat;
                e = exp_q.pop_front();
                lat = cyc - e.t0 - 1;
                n_chk++;
                if (err !== e.err) begin
                    n_bad++;
                    $display("FAIL %s err: actual %0b expected %0b", e.tag, err, e.err);
                end
                n_chk++;
                if (lat != e.lat) begin
                    n_bad++;
                    $display("FAIL %s R7 latency: actual %0d expected %0d", e.tag, lat, e.lat);
                end
                if (e.cmp_lanes) begin
                    n_chk++;
                    if (lanes !== e.lanes) begin
                        n_bad++;
                        $display("FAIL %s lanes: actual %h expected %h", e.tag, lanes, e.lanes);
                    end
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (busy !== 1'b0 || done !== 1'b0 || err !== 1'b0 || lanes !== '0) begin
            n_bad++;
            $display("FAIL R1 reset: actual busy=%b done=%b err=%b lanes_nz=%b expected 0 0 0 0",
                     busy, done, err, |lanes);
        end
        for (int r = 0; r < NREGS; r++) write_reg(r, 0);

        gather(10, 0, 8, 4, 2, 2, 0, "R3 even dwords R4");
        gather(10, 1, 8, 4, 2, 2, 0, "R3 odd dwords R2");
        gather(20, 3, 16, 16, 1, 1, 1, "R6 words R5 xs16");
        gather(40, 5, 32, 32, 1, 0, 2, "R6 bytes R5 xs32");
        gather(5, 7, 0, 1, 0, 2, 0, "R2 broadcast");
        gather(60, 2, 3, 2, 1, 1, 0, "R2 word 2d");
        gather(30, 30, 5, 4, 3, 0, 1, "R4 byte cross");
        gather(8, 0, 0, 3, 1, 2, 0, "R8 width3");
        gather(8, 0, 16, 16, 1, 2, 0, "R8 width gt size");
        gather(8, 0, 8, 8, 1, 3, 0, "R8 type3");
        gather(8, 0, 8, 8, 1, 2, 3, "R8 size3");
        gather(126, 0, 8, 1, 0, 2, 0, "R9 past top");
        gather(127, 31, 1, 1, 0, 0, 0, "R9 byte edge");
        gather(12, 2, 4, 2, 1, 2, 1, "R10 busy start", 1);
        write_reg(10, 99);
        gather(10, 0, 8, 4, 2, 2, 0, "R11 rewrite");
        repeat (10) @(negedge clk);
        summary();
    end
endmodule